// File: doc/BRIEF.md
# Memory Port Write Request Sequencer

This block sits on the master side of a memory controller port and turns user write commands into port transactions. The port has two parts. One is an address handshake with request, acknowledge, read-not-write and transfer-size signals. The other is a write-data FIFO with push, data, byte enables and a full flag.

A user command carries an address, a size code and a declared beat count. The size code selects one of three transfers: a single 64-bit double-word, a burst of eight 32-bit words, or a burst of 64 32-bit words. The data then arrives as a stream of 64-bit beats with byte enables.

The order of the two port phases depends on the size:
- **Single double-word:** the address request goes out first. The one data beat is pushed only after the acknowledge has been seen.
- **Bursts:** every beat is pushed into the FIFO first, and the address request is raised afterwards.

On the way out, the bytes inside each 32-bit word are reversed. A narrow write is a full beat pushed with the byte enables of the unused lanes cleared; those enables are reordered the same way as the data. A command whose beat count does not match its size is rejected with a one-cycle error pulse and is never issued.

Top module: `mem_wr_sequencer`

## Requirements
- R1: For size code 0 (single double-word, 1 beat), the address request rises before any push. The one push happens no earlier than the cycle after the cycle in which request and acknowledge are both high.
- R2: For size codes 1 (4 beats) and 2 (32 beats), every beat of the transfer is pushed before the address request rises. No push occurs while the address request is high.
- R3: Once raised, the address request stays high until the acknowledge is seen. It is low in the cycle after the acknowledge cycle, and each transfer produces exactly one acknowledged request.
- R4: While the address request is high, the address and size outputs equal the accepted command's values and do not change. The read-not-write output is always 0.
- R5: Within each 32-bit word, output byte k equals input byte 3-k (bits [8k+7:8k] of the word). The byte-enable bits are reordered the same way within each group of four. Cleared enables pass through to their swapped lanes.
- R6: No push occurs while the FIFO full flag is high. Every beat is pushed exactly once and in order, across full periods and gaps in the beat stream.
- R7: Command ready is high only when idle. It stays low from command acceptance until both the address phase and all data pushes of that transfer are done.
- R8: A command with size code 3, or with a beat count different from its size's count, produces a one-cycle error pulse. It causes no address request and no push, and the block stays ready.
- R9: The number of pushes per transfer is 1, 4 or 32 for size codes 0, 1 or 2. Beats may arrive with arbitrary gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command valid |
| cmdReady | output | 1 | Command ready (idle) |
| cmdAddr | input | ADDR_W | Command address |
| cmdSize | input | 2 | Size code: 0 double-word, 1 eight-word, 2 64-word, 3 invalid |
| cmdBeats | input | CNT_W | Declared beat count |
| beatValid | input | 1 | Data beat valid |
| beatReady | output | 1 | Data beat ready |
| beatData | input | DATA_W | Beat data, user byte order |
| beatBe | input | DATA_W/8 | Beat byte enables |
| errPulse | output | 1 | One-cycle pulse on a rejected command |
| addrReq | output | 1 | Port address request |
| addrAck | input | 1 | Port address acknowledge |
| addrRnw | output | 1 | Read-not-write, always 0 |
| addrOut | output | ADDR_W | Port address |
| sizeOut | output | 2 | Port transfer size code |
| wrPush | output | 1 | Write FIFO push |
| wrData | output | DATA_W | Write data, bytes swapped per word |
| wrBe | output | DATA_W/8 | Write byte enables, swapped per word |
| wrFull | input | 1 | Write FIFO full |

## Verification
The embedded properties guard the ordering rules on every cycle:
- a single double-word is never pushed before its acknowledge;
- a burst request never rises before its last push;
- no push overlaps a pending request;
- the request is held until acknowledged and dropped right after;
- the address and size stay stable while waiting;
- no push happens into a full FIFO.

Only the bench scenarios, driven by a reactive port model, can show the rest:
- the byte-lane reversal of data and enables;
- that every beat arrives exactly once and in order through gaps and full periods;
- the push counts per size;
- that ready stays low for the whole transfer;
- that bad beat counts are rejected without side effects.

// File: rtl/mws_pkg.sv
package mws_pkg;

  typedef enum logic [1:0] {
    SZ_DWORD   = 2'd0,
    SZ_BURST8  = 2'd1,
    SZ_BURST64 = 2'd2,
    SZ_RSVD    = 2'd3
  } size_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCmd;
    logic pushBeat;
  } dp_ctrl_t;

  function automatic int beatsFor(size_e sz, int b8, int b64);
    case (sz)
      SZ_DWORD:   return 1;
      SZ_BURST8:  return b8;
      SZ_BURST64: return b64;
      default:    return 0;
    endcase
  endfunction

endpackage

// File: rtl/mws_datapath.sv
module mws_datapath
  import mws_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  parameter int WORD_W    = 32,
  parameter int CNT_W     = 6,
  parameter int BEATS_B8  = 4,
  parameter int BEATS_B64 = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dp_ctrl_t              ctl,
  input  logic [ADDR_W-1:0]     cmdAddr,
  input  size_e                 cmdSize,
  input  logic [DATA_W-1:0]     beatData,
  input  logic [DATA_W/8-1:0]   beatBe,
  output logic [ADDR_W-1:0]     addrOut,
  output size_e                 sizeQ,
  output logic [DATA_W-1:0]     wrData,
  output logic [DATA_W/8-1:0]   wrBe,
  output logic                  lastBeat
);

  localparam int WORD_BYTES = WORD_W / 8;
  localparam int NUM_WORDS  = DATA_W / WORD_W;

  logic [ADDR_W-1:0] addrQ;
  logic [CNT_W-1:0]  leftQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      sizeQ <= SZ_DWORD;
      leftQ <= '0;
    end else if (ctl.loadCmd) begin
      addrQ <= cmdAddr;
      sizeQ <= cmdSize;
      leftQ <= CNT_W'(beatsFor(cmdSize, BEATS_B8, BEATS_B64));
    end else if (ctl.pushBeat) begin
      leftQ <= leftQ - 1'b1;
    end
  end

  assign addrOut  = addrQ;
  assign lastBeat = (leftQ == CNT_W'(1));

  // byte lane reversal inside each word
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byte
      assign wrData[w*WORD_W + b*8 +: 8] =
        beatData[w*WORD_W + (WORD_BYTES-1-b)*8 +: 8];
      assign wrBe[w*WORD_BYTES + b] = beatBe[w*WORD_BYTES + (WORD_BYTES-1-b)];
    end
  end

  a_r9_no_extra_push: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pushBeat |-> (leftQ != '0));

endmodule

// File: rtl/mws_ctrl.sv
module mws_ctrl
  import mws_pkg::*;
#(
  parameter int CNT_W     = 6,
  parameter int BEATS_B8  = 4,
  parameter int BEATS_B64 = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  size_e            cmdSize,
  input  logic [CNT_W-1:0] cmdBeats,
  output logic             cmdReady,
  input  logic             beatValid,
  output logic             beatReady,
  input  logic             wrFull,
  output logic             wrPush,
  output logic             addrReq,
  input  logic             addrAck,
  output logic             errPulse,
  input  size_e            sizeQ,
  input  logic             lastBeat,
  output dp_ctrl_t         ctl
);

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_PUSH} state_e;

  state_e           state;
  logic             reqQ, errQ, ackSeenQ, pushDoneQ;
  logic             cmdBad;
  logic [CNT_W-1:0] expBeats;

  always_comb begin
    expBeats  = CNT_W'(beatsFor(cmdSize, BEATS_B8, BEATS_B64));
    cmdBad    = (cmdSize == SZ_RSVD) || (cmdBeats != expBeats);
    cmdReady  = (state == ST_IDLE);
    beatReady = (state == ST_PUSH) && !wrFull;
    wrPush    = beatReady && beatValid;
    ctl.loadCmd  = cmdReady && cmdValid && !cmdBad;
    ctl.pushBeat = wrPush;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      reqQ  <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      errQ <= cmdReady && cmdValid && cmdBad;
      case (state)
        ST_IDLE: if (ctl.loadCmd) begin
          if (cmdSize == SZ_DWORD) begin
            state <= ST_REQ;
            reqQ  <= 1'b1;
          end else begin
            state <= ST_PUSH;
          end
        end
        ST_PUSH: if (wrPush && lastBeat) begin
          if (sizeQ == SZ_DWORD) begin
            state <= ST_IDLE;
          end else begin
            state <= ST_REQ;
            reqQ  <= 1'b1;
          end
        end
        ST_REQ: if (addrAck) begin
          reqQ  <= 1'b0;
          state <= (sizeQ == SZ_DWORD) ? ST_PUSH : ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // progress flags used only to guard the ordering rules
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackSeenQ  <= 1'b0;
      pushDoneQ <= 1'b0;
    end else if (ctl.loadCmd) begin
      ackSeenQ  <= 1'b0;
      pushDoneQ <= 1'b0;
    end else begin
      if (reqQ && addrAck)    ackSeenQ  <= 1'b1;
      if (wrPush && lastBeat) pushDoneQ <= 1'b1;
    end
  end

  assign addrReq  = reqQ;
  assign errPulse = errQ;

  a_r1_dword_push_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    (wrPush && sizeQ == SZ_DWORD) |-> ackSeenQ);
  a_r2_burst_data_first: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(addrReq) && sizeQ != SZ_DWORD) |-> pushDoneQ);
  a_r2_no_push_during_req: assert property (@(posedge clk) disable iff (!rstN)
    addrReq |-> !wrPush);
  a_r3_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (addrReq && !addrAck) |=> addrReq);
  a_r3_req_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (addrReq && addrAck) |=> !addrReq);
  a_r7_ready_only_idle: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> (!addrReq && !beatReady));
  a_r8_error_no_issue: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> (cmdReady && !addrReq && !wrPush));

endmodule

// File: rtl/mem_wr_sequencer.sv
module mem_wr_sequencer
  import mws_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int WORD_W = 32,
  localparam int BEATS_B8  = (8 * WORD_W) / DATA_W,
  localparam int BEATS_B64 = (64 * WORD_W) / DATA_W,
  localparam int CNT_W     = $clog2(BEATS_B64 + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  output logic                cmdReady,
  input  logic [ADDR_W-1:0]   cmdAddr,
  input  logic [1:0]          cmdSize,
  input  logic [CNT_W-1:0]    cmdBeats,
  input  logic                beatValid,
  output logic                beatReady,
  input  logic [DATA_W-1:0]   beatData,
  input  logic [DATA_W/8-1:0] beatBe,
  output logic                errPulse,
  output logic                addrReq,
  input  logic                addrAck,
  output logic                addrRnw,
  output logic [ADDR_W-1:0]   addrOut,
  output logic [1:0]          sizeOut,
  output logic                wrPush,
  output logic [DATA_W-1:0]   wrData,
  output logic [DATA_W/8-1:0] wrBe,
  input  logic                wrFull
);

  size_e    cmdSizeE, sizeQ;
  dp_ctrl_t ctl;
  logic     lastBeat;

  assign cmdSizeE = size_e'(cmdSize);
  assign sizeOut  = sizeQ;
  assign addrRnw  = 1'b0;

  mws_ctrl #(
    .CNT_W(CNT_W), .BEATS_B8(BEATS_B8), .BEATS_B64(BEATS_B64)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdSize(cmdSizeE), .cmdBeats(cmdBeats), .cmdReady(cmdReady),
    .beatValid(beatValid), .beatReady(beatReady),
    .wrFull(wrFull), .wrPush(wrPush),
    .addrReq(addrReq), .addrAck(addrAck), .errPulse(errPulse),
    .sizeQ(sizeQ), .lastBeat(lastBeat), .ctl(ctl)
  );

  mws_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_W(WORD_W), .CNT_W(CNT_W),
    .BEATS_B8(BEATS_B8), .BEATS_B64(BEATS_B64)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .cmdAddr(cmdAddr), .cmdSize(cmdSizeE),
    .beatData(beatData), .beatBe(beatBe),
    .addrOut(addrOut), .sizeQ(sizeQ),
    .wrData(wrData), .wrBe(wrBe), .lastBeat(lastBeat)
  );

  a_r4_req_fields_stable: assert property (@(posedge clk) disable iff (!rstN)
    (addrReq && !addrAck) |=> ($stable(addrOut) && $stable(sizeOut)));
  a_r4_write_only: assert property (@(posedge clk) disable iff (!rstN)
    !addrRnw);
  a_r6_no_push_when_full: assert property (@(posedge clk) disable iff (!rstN)
    wrFull |-> !wrPush);

endmodule

// File: tb/mem_wr_sequencer_bench.sv
module mem_wr_sequencer_bench;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;
  localparam int CNT_W  = 6;
  localparam int NT     = 10;

  // table: size, declared beats, ack delay, gap mode, full mode, expect error
  localparam int T_SIZE [NT] = '{0, 0, 1, 1, 2, 2, 2, 1, 3, 0};
  localparam int T_BEATS[NT] = '{1, 1, 4, 4, 32, 32, 32, 5, 1, 1};
  localparam int T_ACK  [NT] = '{1, 4, 0, 2, 3, 0, 1, 0, 0, 0};
  localparam int T_GAP  [NT] = '{0, 1, 0, 1, 1, 0, 2, 0, 0, 0};
  localparam int T_FULL [NT] = '{0, 0, 0, 1, 0, 1, 1, 0, 0, 1};
  localparam int T_ERR  [NT] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic cmdReady;
  logic [ADDR_W-1:0] cmdAddr = '0;
  logic [1:0] cmdSize = '0;
  logic [CNT_W-1:0] cmdBeats = '0;
  logic beatValid = 1'b0;
  logic beatReady;
  logic [DATA_W-1:0] beatData = '0;
  logic [DATA_W/8-1:0] beatBe = '0;
  logic errPulse, addrReq, addrRnw, wrPush;
  logic addrAck = 1'b0;
  logic wrFull = 1'b0;
  logic [ADDR_W-1:0] addrOut;
  logic [1:0] sizeOut;
  logic [DATA_W-1:0] wrData;
  logic [DATA_W/8-1:0] wrBe;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  mem_wr_sequencer u_mem_wr_sequencer (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdAddr(cmdAddr), .cmdSize(cmdSize), .cmdBeats(cmdBeats),
    .beatValid(beatValid), .beatReady(beatReady), .beatData(beatData), .beatBe(beatBe),
    .errPulse(errPulse), .addrReq(addrReq), .addrAck(addrAck), .addrRnw(addrRnw),
    .addrOut(addrOut), .sizeOut(sizeOut), .wrPush(wrPush), .wrData(wrData),
    .wrBe(wrBe), .wrFull(wrFull)
  );

  // ---------- port model configuration (written by the test sequence)
  int txnId = 0;
  int nBeats = 0, ackDelay = 0, gapMode = 0, fullMode = 0, expErr = 0;
  logic [ADDR_W-1:0] expAddr = '0;
  logic [1:0] expSize = '0;

  // ---------- model state and observations
  int cyc = 0, seenTxn = 0;
  int pushCnt = 0, ackCnt = 0, errCnt = 0, waitCnt = 0;
  int reqRise = -1, ackCyc = -1, firstPush = -1, lastPush = -1;
  int dataBad = 0, fullViol = 0, dropViol = 0, stabViol = 0, readyViol = 0;
  logic accepted = 1'b0, prevReq = 1'b0, prevAckHs = 1'b0, nextAck = 1'b0;

  function automatic logic [DATA_W-1:0] patData(int t, int i);
    return {8'(t), 8'(i), 8'hC3, 8'h5A, 8'(i * 7 + 1), 8'h96, 8'(t + 3), 8'h0F};
  endfunction

  function automatic logic [DATA_W/8-1:0] patBe(int t, int i);
    return (((t + i) % 2) == 1) ? 8'hF0 : 8'h3C;
  endfunction

  function automatic logic [DATA_W-1:0] swapData(logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r;
    for (int w = 0; w < 2; w++)
      for (int b = 0; b < 4; b++)
        r[w*32 + b*8 +: 8] = d[w*32 + (3-b)*8 +: 8];
    return r;
  endfunction

  function automatic logic [DATA_W/8-1:0] swapBe(logic [DATA_W/8-1:0] e);
    logic [DATA_W/8-1:0] r;
    for (int w = 0; w < 2; w++)
      for (int b = 0; b < 4; b++)
        r[w*4 + b] = e[w*4 + 3 - b];
    return r;
  endfunction

  function automatic logic complete();
    return (ackCnt == 1) && (pushCnt == nBeats);
  endfunction

  // reactive port controller model + monitor
  always begin
    @(negedge clk);
    cyc++;
    if (rstN) begin
      if (txnId != seenTxn) begin
        seenTxn = txnId;
        pushCnt = 0; ackCnt = 0; errCnt = 0; waitCnt = 0;
        reqRise = -1; ackCyc = -1; firstPush = -1; lastPush = -1;
        dataBad = 0; fullViol = 0; dropViol = 0; stabViol = 0; readyViol = 0;
        accepted = 1'b0;
      end
      if (prevAckHs && addrReq) dropViol++;
      if (addrReq && !prevReq) reqRise = cyc;
      if (addrReq && (addrOut != expAddr || sizeOut != expSize)) stabViol++;
      if (addrRnw) stabViol++;
      if (accepted && expErr == 0 && !complete() && cmdReady) readyViol++;
      if (wrFull && wrPush) fullViol++;
      if (wrPush) begin
        if (wrData != swapData(patData(txnId, pushCnt)) ||
            wrBe != swapBe(patBe(txnId, pushCnt))) dataBad++;
        if (firstPush < 0) firstPush = cyc;
        lastPush = cyc;
        pushCnt++;
      end
      if (errPulse) errCnt++;
      if (cmdValid && cmdReady) accepted = 1'b1;
      nextAck = 1'b0;
      if (addrReq && addrAck) begin
        ackCyc = cyc;
        ackCnt++;
        waitCnt = 0;
      end else if (addrReq) begin
        if (waitCnt >= ackDelay) nextAck = 1'b1;
        else waitCnt++;
      end
      prevAckHs = addrReq && addrAck;
      prevReq = addrReq;
    end
    @(posedge clk);
    #1;
    addrAck   = nextAck;
    wrFull    = (fullMode != 0) && ((cyc % 4 == 1) || (cyc % 4 == 2));
    beatValid = (pushCnt < nBeats) &&
                ((gapMode == 0) || (gapMode == 1 && cyc % 3 != 0) ||
                 (gapMode == 2 && cyc % 7 == 0));
    beatData  = patData(txnId, pushCnt);
    beatBe    = patBe(txnId, pushCnt);
  end

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic runTxn(input int i);
    int waited;
    logic done;
    @(posedge clk); #1;
    txnId    = i + 1;
    nBeats   = T_BEATS[i];
    ackDelay = T_ACK[i];
    gapMode  = T_GAP[i];
    fullMode = T_FULL[i];
    expErr   = T_ERR[i];
    expAddr  = ADDR_W'(32'h1000 + i * 32'h100);
    expSize  = 2'(T_SIZE[i]);
    repeat (2) @(posedge clk);
    #1;
    cmdAddr  = expAddr;
    cmdSize  = expSize;
    cmdBeats = CNT_W'(T_BEATS[i]);
    cmdValid = 1'b1;
    waited = 0;
    done = 1'b0;
    while (!done && waited < 3000) begin
      @(negedge clk);
      waited++;
      if (cmdReady) done = 1'b1;
    end
    @(posedge clk); #1;
    cmdValid = 1'b0;
    done = 1'b0;
    while (!done && waited < 3000) begin
      @(negedge clk);
      waited++;
      if (expErr != 0 ? (waited > 6) : complete()) done = 1'b0 == 1'b1 ? 1'b0 : 1'b1;
    end
    if (!done) check(1'b0, "R7", "watchdog transfer completion", waited, 3000);
    repeat (3) @(negedge clk);
    if (expErr != 0) begin
      check(errCnt == 1, "R8", "error pulses", errCnt, 1);
      check(pushCnt == 0, "R8", "pushes after bad command", pushCnt, 0);
      check(reqRise == -1, "R8", "address request after bad command", reqRise, -1);
      check(cmdReady == 1'b1, "R8", "ready after bad command", int'(cmdReady), 1);
    end else begin
      check(pushCnt == nBeats, "R9", "push count", pushCnt, nBeats);
      check(dataBad == 0, "R5", "swapped data/enable mismatches", dataBad, 0);
      check(ackCnt == 1, "R3", "acknowledged requests", ackCnt, 1);
      check(dropViol == 0, "R3", "request high after ack", dropViol, 0);
      check(stabViol == 0, "R4", "address/size/rnw deviations", stabViol, 0);
      check(fullViol == 0, "R6", "pushes while full", fullViol, 0);
      check(readyViol == 0, "R7", "ready high mid-transfer", readyViol, 0);
      check(errCnt == 0, "R8", "spurious error pulses", errCnt, 0);
      if (T_SIZE[i] == 0) begin
        check(firstPush > ackCyc, "R1", "push cycle vs ack cycle", firstPush, ackCyc + 1);
        check(reqRise >= 0 && reqRise < firstPush, "R1", "request rise vs push", reqRise, firstPush - 1);
      end else begin
        check(lastPush >= 0 && lastPush < reqRise, "R2", "last push vs request rise", lastPush, reqRise - 1);
      end
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(cmdReady == 1'b1, "R7", "ready after reset", int'(cmdReady), 1);
    check(addrReq == 1'b0, "R3", "request after reset", int'(addrReq), 0);
    check(wrPush == 1'b0, "R6", "push after reset", int'(wrPush), 0);
    check(errPulse == 1'b0, "R8", "error after reset", int'(errPulse), 0);
    check(addrRnw == 1'b0, "R4", "rnw after reset", int'(addrRnw), 0);
    for (int i = 0; i < NT; i++) runTxn(i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule